// File: doc/BRIEF.md
# Queue-Fed Dataflow Compute Node Array

This block is a small array of compute nodes that have no program counter. Each node watches one or two named FIFO queues. It fires as soon as its operands are present and every queue it writes has room. It computes an address or a loop-control value and pushes that one result into every queue selected by its destination mask, all in the same cycle. An operand can also be a configured constant, so an address such as "index plus base" or an increment such as "counter plus one" takes a single node. A compare node turns "counter below bound" into a 0/1 token in a queue.

A controller moves between two named states. In `ST_CFG` (configure), node configuration writes are accepted and no node fires. In `ST_RUN` (run), nodes fire and configuration writes are ignored. The transition `ST_CFG`→`ST_RUN` is taken when `run_en` is high at a clock edge, and `ST_RUN`→`ST_CFG` when it is low. Surrounding logic reaches the queues through one external push port and one external pop port, which work in both states. When an external push or pop names a queue, nodes that touch that queue wait for that cycle. A round-robin pointer decides among ready nodes that share any queue. The pointer moves to the node just after the first winner.

Top module: `dfn_array`

## Requirements
- R1: After reset every queue is empty and not full, `running` is 0, and no node is active (a node is active when its destination mask is non-zero).
- R2: Each queue is a 4-entry FIFO of 32-bit values. `q_full` rises after the fourth push, values leave in push order, and an external push to a full queue is dropped.
- R3: Configuration writes (`cfg_we`) take effect only while `running` is 0. A write made while running leaves the node unchanged.
- R4: A node never fires while `running` is 0. While running it fires when its sources become non-empty, including values that arrive after the run has started.
- R5: Opcode 0 (add) pushes A + B, where B is either `cfg_imm` (when `cfg_use_imm` = 1) or the head of queue `cfg_src_b`.
- R6: Opcode 1 (subtract) pushes A − B modulo 2^32. A firing pops each distinct source queue exactly once.
- R7: Opcode 2 (signed less-than) pushes 1 when A < B as two's-complement numbers, and 0 otherwise.
- R8: Opcode 3 (unsigned less-than) pushes 1 when A < B as unsigned numbers, and 0 otherwise.
- R9: One firing pushes the same result into every queue set in the destination mask (bit q selects queue q). If any of those queues is full, the node does not fire and its source is not popped.
- R10: When two ready nodes write the same queue, only one fires per cycle, and the winners alternate between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Request for the run state |
| cfg_we | input | 1 | Node configuration write strobe |
| cfg_node | input | NODE_W | Node to configure |
| cfg_op | input | 2 | Opcode: 0 add, 1 sub, 2 signed lt, 3 unsigned lt |
| cfg_src_a | input | QID_W | Queue for operand A |
| cfg_src_b | input | QID_W | Queue for operand B |
| cfg_use_imm | input | 1 | 1 selects the constant for operand B |
| cfg_imm | input | DW | Constant operand |
| cfg_dst | input | NQ | Destination queue mask |
| ext_push | input | 1 | External push strobe |
| ext_push_qid | input | QID_W | Queue for external push |
| ext_push_data | input | DW | Value to push |
| ext_pop | input | 1 | External pop strobe |
| ext_pop_qid | input | QID_W | Queue for external pop, also selects the head shown |
| ext_pop_data | output | DW | Head of queue `ext_pop_qid` |
| q_empty | output | NQ | Per-queue empty flags |
| q_full | output | NQ | Per-queue full flags |
| running | output | 1 | 1 in `ST_RUN` |

## Verification
The hardest case to reach from the ports is two ready nodes contending for one destination queue in the same cycle, because firing starts the moment operands arrive. The stimulus therefore loads both source queues while the array is in the configure state and only then enters the run state, so both nodes become ready on the same edge. The stalled-multicast case is set up in the same way. One destination is pre-filled to full before the run, then drained by one entry after the run stops, and the delayed firing is observed.

// File: rtl/dfn_pkg.sv
package dfn_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_SLT = 2'd2,
        OP_ULT = 2'd3
    } dfn_op_e;

    typedef enum logic {
        ST_CFG = 1'b0,
        ST_RUN = 1'b1
    } dfn_state_e;

endpackage

// File: rtl/dfn_queue.sv
module dfn_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign head_o  = mem_q[rd_q];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_q] <= push_data_i;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/dfn_alu.sv
module dfn_alu
    import dfn_pkg::*;
#(
    parameter int DW = 32
) (
    input  dfn_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_SLT:  y_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            OP_ULT:  y_o = {{(DW-1){1'b0}}, (a_i < b_i)};
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/dfn_rr_grant.sv
module dfn_rr_grant #(
    parameter int N  = 4,
    parameter int QN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          ready_i,
    input  logic [N-1:0][QN-1:0]  use_i,
    output logic [N-1:0]          grant_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q, ptr_d;
    logic [QN-1:0] taken;
    logic          found;
    int            first_idx;

    always_comb begin
        grant_o   = '0;
        taken     = '0;
        found     = 1'b0;
        first_idx = 0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (ready_i[idx] && ((use_i[idx] & taken) == '0)) begin
                grant_o[idx] = 1'b1;
                taken        = taken | use_i[idx];
                if (!found) begin
                    found     = 1'b1;
                    first_idx = idx;
                end
            end
        end
        ptr_d = ptr_q;
        if (found) begin
            if (first_idx == N - 1) begin
                ptr_d = '0;
            end else begin
                ptr_d = PW'(first_idx + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R10
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~ready_i) == '0);

endmodule

// File: rtl/dfn_array.sv
module dfn_array
    import dfn_pkg::*;
#(
    parameter int NN     = 4,
    parameter int NQ     = 8,
    parameter int DW     = 32,
    parameter int QDEPTH = 4,
    parameter int NODE_W = (NN > 1) ? $clog2(NN) : 1,
    parameter int QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [NODE_W-1:0] cfg_node,
    input  logic [1:0]        cfg_op,
    input  logic [QID_W-1:0]  cfg_src_a,
    input  logic [QID_W-1:0]  cfg_src_b,
    input  logic              cfg_use_imm,
    input  logic [DW-1:0]     cfg_imm,
    input  logic [NQ-1:0]     cfg_dst,
    input  logic              ext_push,
    input  logic [QID_W-1:0]  ext_push_qid,
    input  logic [DW-1:0]     ext_push_data,
    input  logic              ext_pop,
    input  logic [QID_W-1:0]  ext_pop_qid,
    output logic [DW-1:0]     ext_pop_data,
    output logic [NQ-1:0]     q_empty,
    output logic [NQ-1:0]     q_full,
    output logic              running
);
    localparam logic [NQ-1:0] QBIT0 = {{(NQ-1){1'b0}}, 1'b1};

    // ---------------- control state machine ----------------
    dfn_state_e state_q, state_d;
    logic       cfg_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CFG;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG:  if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_CFG;
            default: state_d = ST_CFG;
        endcase
    end

    always_comb begin
        running  = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_CFG:  cfg_open = 1'b1;
            ST_RUN:  running  = 1'b1;
            default: cfg_open = 1'b0;
        endcase
    end

    // ---------------- configuration registers ----------------
    dfn_op_e                      op_r   [NN];
    logic [NN-1:0][QID_W-1:0]     srca_r;
    logic [NN-1:0][QID_W-1:0]     srcb_r;
    logic [NN-1:0]                useimm_r;
    logic [NN-1:0][DW-1:0]        imm_r;
    logic [NN-1:0][NQ-1:0]        dst_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NN; i++) begin
                op_r[i] <= OP_ADD;
            end
            srca_r   <= '0;
            srcb_r   <= '0;
            useimm_r <= '0;
            imm_r    <= '0;
            dst_r    <= '0;
        end else if (cfg_open && cfg_we && (int'(cfg_node) < NN)) begin
            op_r[cfg_node]     <= dfn_op_e'(cfg_op);
            srca_r[cfg_node]   <= cfg_src_a;
            srcb_r[cfg_node]   <= cfg_src_b;
            useimm_r[cfg_node] <= cfg_use_imm;
            imm_r[cfg_node]    <= cfg_imm;
            dst_r[cfg_node]    <= cfg_dst;
        end
    end

    // ---------------- queues ----------------
    logic [DW-1:0] q_head  [NQ];
    logic [DW-1:0] q_wdata [NQ];
    logic [NQ-1:0] q_push, q_pop;
    logic [NQ-1:0] ext_busy;
    logic          ext_push_ok, ext_pop_ok;

    assign ext_push_ok  = ext_push && !q_full[ext_push_qid];
    assign ext_pop_ok   = ext_pop && !q_empty[ext_pop_qid];
    assign ext_pop_data = q_head[ext_pop_qid];
    assign ext_busy     = (ext_push ? (QBIT0 << ext_push_qid) : '0)
                        | (ext_pop  ? (QBIT0 << ext_pop_qid)  : '0);

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_queue
            dfn_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
                .clk         (clk),
                .rst_n       (rst_n),
                .push_i      (q_push[q]),
                .push_data_i (q_wdata[q]),
                .pop_i       (q_pop[q]),
                .head_o      (q_head[q]),
                .empty_o     (q_empty[q]),
                .full_o      (q_full[q])
            );
        end
    endgenerate

    // ---------------- nodes ----------------
    logic [NN-1:0][DW-1:0] node_res;
    logic [NN-1:0][NQ-1:0] node_src;
    logic [NN-1:0][NQ-1:0] node_use;
    logic [NN-1:0]         node_ready;
    logic [NN-1:0]         node_grant;

    generate
        for (genvar i = 0; i < NN; i++) begin : g_node
            logic [DW-1:0] opa, opb;
            logic          srcs_ok;

            assign opa = q_head[srca_r[i]];
            assign opb = useimm_r[i] ? imm_r[i] : q_head[srcb_r[i]];

            dfn_alu #(.DW(DW)) u_alu (
                .op_i (op_r[i]),
                .a_i  (opa),
                .b_i  (opb),
                .y_o  (node_res[i])
            );

            assign node_src[i] = (QBIT0 << srca_r[i])
                               | (useimm_r[i] ? '0 : (QBIT0 << srcb_r[i]));
            assign node_use[i] = node_src[i] | dst_r[i];
            assign srcs_ok     = !q_empty[srca_r[i]]
                               && (useimm_r[i] || !q_empty[srcb_r[i]]);
            assign node_ready[i] = running && (dst_r[i] != '0) && srcs_ok
                                 && ((dst_r[i] & q_full) == '0)
                                 && ((node_use[i] & ext_busy) == '0);
        end
    endgenerate

    dfn_rr_grant #(.N(NN), .QN(NQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (node_ready),
        .use_i   (node_use),
        .grant_o (node_grant)
    );

    // ---------------- queue port steering ----------------
    logic [NQ-1:0][NN-1:0] q_writers;

    always_comb begin
        q_push    = '0;
        q_pop     = '0;
        q_writers = '0;
        for (int q = 0; q < NQ; q++) begin
            q_wdata[q] = ext_push_data;
            if (ext_push_ok && (int'(ext_push_qid) == q)) begin
                q_push[q] = 1'b1;
            end
            if (ext_pop_ok && (int'(ext_pop_qid) == q)) begin
                q_pop[q] = 1'b1;
            end
            for (int i = 0; i < NN; i++) begin
                if (node_grant[i] && dst_r[i][q]) begin
                    q_push[q]       = 1'b1;
                    q_wdata[q]      = node_res[i];
                    q_writers[q][i] = 1'b1;
                end
                if (node_grant[i] && node_src[i][q]) begin
                    q_pop[q] = 1'b1;
                end
            end
        end
    end

    // R4
    fire_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_grant != '0) |-> (state_q == ST_RUN));

    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(dst_r));

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_wr_chk
            // R10
            single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(q_writers[q]));
        end
    endgenerate

endmodule

// File: tb/dfn_array_tb.sv
`timescale 1ns/1ps
module dfn_array_tb_top;
    localparam int NQ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_node = '0;
    logic [1:0]  cfg_op = '0;
    logic [2:0]  cfg_src_a = '0;
    logic [2:0]  cfg_src_b = '0;
    logic        cfg_use_imm = 1'b0;
    logic [31:0] cfg_imm = '0;
    logic [7:0]  cfg_dst = '0;
    logic        ext_push = 1'b0;
    logic [2:0]  ext_push_qid = '0;
    logic [31:0] ext_push_data = '0;
    logic        ext_pop = 1'b0;
    logic [2:0]  ext_pop_qid = '0;
    logic [31:0] ext_pop_data;
    logic [7:0]  q_empty, q_full;
    logic        running;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    dfn_array dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cfg_we(cfg_we), .cfg_node(cfg_node), .cfg_op(cfg_op),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
        .cfg_use_imm(cfg_use_imm), .cfg_imm(cfg_imm), .cfg_dst(cfg_dst),
        .ext_push(ext_push), .ext_push_qid(ext_push_qid),
        .ext_push_data(ext_push_data), .ext_pop(ext_pop),
        .ext_pop_qid(ext_pop_qid), .ext_pop_data(ext_pop_data),
        .q_empty(q_empty), .q_full(q_full), .running(running)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(int n, logic [1:0] op, int sa, int sb, bit ui,
                       logic [31:0] imm, logic [7:0] dst);
        @(negedge clk);
        cfg_we = 1'b1; cfg_node = 2'(n); cfg_op = op;
        cfg_src_a = 3'(sa); cfg_src_b = 3'(sb);
        cfg_use_imm = ui; cfg_imm = imm; cfg_dst = dst;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(int q, logic [31:0] v);
        @(negedge clk);
        ext_push = 1'b1; ext_push_qid = 3'(q); ext_push_data = v;
        @(negedge clk);
        ext_push = 1'b0;
    endtask

    task automatic expect_val(logic [31:0] v, string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // monitor side: pop the queue, compare with the scoreboard
    task automatic drain(int q, int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] e;
            string       t;
            @(negedge clk);
            ext_pop = 1'b1; ext_pop_qid = 3'(q);
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(!q_empty[q] && ext_pop_data == e, t, ext_pop_data, e);
        end
        @(negedge clk);
        ext_pop = 1'b0;
    endtask

    task automatic run_for(int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(q_empty == 8'hFF && q_full == 8'h00 && !running, "R1",
              {16'd0, q_full, q_empty}, 32'h0000_00FF);

        // R2: depth, order, drop on full
        for (int k = 0; k < 5; k++) push(0, 32'h100 + 32'(k));
        check(q_full[0] == 1'b1, "R2", 32'(q_full[0]), 32'd1);
        for (int k = 0; k < 4; k++) expect_val(32'h100 + 32'(k), "R2");
        drain(0, 4);
        check(q_empty[0] == 1'b1, "R2", 32'(q_empty[0]), 32'd1);

        // R4 / R5: add immediate, node0 q0 -> q1
        cfg(0, 2'd0, 0, 0, 1'b1, 32'd5, 8'b0000_0010);
        push(0, 32'd10);
        repeat (3) @(negedge clk);
        check(q_empty[1] == 1'b1, "R4", 32'(q_empty[1]), 32'd1);
        @(negedge clk);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        push(0, 32'd20);
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(q_empty[0] == 1'b1, "R4", 32'(q_empty[0]), 32'd1);
        expect_val(32'd15, "R5");
        expect_val(32'd25, "R4");
        drain(1, 2);
        cfg(0, 2'd0, 0, 0, 1'b1, 32'd0, 8'h00);

        // R6: subtract two queues, node1 q2 - q3 -> q4
        cfg(1, 2'd1, 2, 3, 1'b0, 32'd0, 8'b0001_0000);
        push(2, 32'd100); push(2, 32'd7);
        push(3, 32'd30);  push(3, 32'd10);
        run_for(6);
        check(q_empty[2] && q_empty[3], "R6", {30'd0, q_empty[3:2]}, 32'd3);
        expect_val(32'd70, "R6");
        expect_val(32'hFFFF_FFFD, "R6");
        drain(4, 2);

        // R7: signed less-than against 0
        cfg(1, 2'd2, 2, 0, 1'b1, 32'd0, 8'b0001_0000);
        push(2, 32'hFFFF_FFFF); push(2, 32'd5);
        run_for(5);
        expect_val(32'd1, "R7");
        expect_val(32'd0, "R7");
        drain(4, 2);

        // R8: unsigned less-than against 16
        cfg(1, 2'd3, 2, 0, 1'b1, 32'h10, 8'b0001_0000);
        push(2, 32'hFFFF_FFFF); push(2, 32'd3);
        run_for(5);
        expect_val(32'd0, "R8");
        expect_val(32'd1, "R8");
        drain(4, 2);
        cfg(1, 2'd0, 0, 0, 1'b1, 32'd0, 8'h00);

        // R9: multicast q5+1 -> q6,q7 with q7 full first
        cfg(2, 2'd0, 5, 0, 1'b1, 32'd1, 8'b1100_0000);
        for (int k = 0; k < 4; k++) push(7, 32'd40 + 32'(k));
        push(5, 32'd9);
        run_for(5);
        check(q_empty[6] == 1'b1, "R9", 32'(q_empty[6]), 32'd1);
        check(q_empty[5] == 1'b0, "R9", 32'(q_empty[5]), 32'd0);
        expect_val(32'd40, "R9");
        drain(7, 1);
        run_for(4);
        check(q_empty[5] == 1'b1, "R9", 32'(q_empty[5]), 32'd1);
        expect_val(32'd10, "R9");
        drain(6, 1);
        expect_val(32'd41, "R9"); expect_val(32'd42, "R9");
        expect_val(32'd43, "R9"); expect_val(32'd10, "R9");
        drain(7, 4);

        // R3: write while running is ignored
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        cfg(3, 2'd0, 0, 0, 1'b1, 32'd1, 8'b0000_0010);
        push(0, 32'd7);
        repeat (4) @(negedge clk);
        check(q_empty[1] == 1'b1, "R3", 32'(q_empty[1]), 32'd1);
        run_en = 1'b0;
        @(negedge clk);
        expect_val(32'd7, "R3");
        drain(0, 1);

        // R10: two nodes share q2; winners alternate
        cfg(0, 2'd0, 0, 0, 1'b1, 32'd100, 8'b0000_0100);
        cfg(3, 2'd0, 1, 0, 1'b1, 32'd200, 8'b0000_0100);
        push(0, 32'd1); push(0, 32'd2);
        push(1, 32'd3); push(1, 32'd4);
        run_for(8);
        check(q_full[2] == 1'b1, "R10", 32'(q_full[2]), 32'd1);
        @(negedge clk);
        ext_pop_qid = 3'd2;
        #1;
        first = ext_pop_data;
        if (first == 32'd101) begin
            expect_val(32'd101, "R10"); expect_val(32'd203, "R10");
            expect_val(32'd102, "R10"); expect_val(32'd204, "R10");
        end else begin
            expect_val(32'd203, "R10"); expect_val(32'd101, "R10");
            expect_val(32'd204, "R10"); expect_val(32'd102, "R10");
        end
        drain(2, 4);
        check(q_empty == 8'hFF, "R10", {24'd0, q_empty}, 32'h0000_00FF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule